// File: doc/BRIEF.md
# Use-Last Translation Lookaside Buffer

This block is a small, fully associative translation buffer that turns a virtual address into a physical address and checks the page's read, write and execute rights. A lookup is answered combinationally in the cycle it is presented. The registered hit, miss and fault flags follow one clock later. After a miss, a refill port writes a new translation into the next slot in round-robin order.

To save power, the block keeps one last-use register with the most recently resolved translation. When a lookup falls in the same page as the lookup before it, the associative entry array is left idle and the held translation is reused. The permission check still runs on every lookup. When the array is activated, a one-cycle enable strobe is raised and a saturating page-switch counter advances. Together these show how often the array really had to be read.

Top module: `lastuse_tlb`

## Requirements
- R1: Any slot may hold any virtual page. A lookup that matches a valid slot and is permitted gives a physical address in the same cycle, made of the slot's physical page number above the unchanged page offset (offset width = log2 of PAGE_BYTES, default 12).
- R2: Permissions are the 3-bit field {execute, write, read}, with read at bit 0. The access codes are 0 = read, 1 = write, 2 = execute and 3 = never permitted. A found translation that does not permit the access raises fault and no hit. This check applies whether the translation came from the array or from the last-use register.
- R3: A valid lookup whose page equals that of the last-use register, while that register is valid, keeps `array_en` low and takes its result from the register.
- R4: A valid lookup whose page differs from the last-use register, or that arrives while the register is invalid, raises `array_en` in the same cycle. A lookup with `lk_valid` low never raises it.
- R5: `hit_q`, `miss_q` and `fault_q` show the result of the lookup from the previous cycle. Exactly one of them is high after a lookup, and all are low after a cycle without one.
- R6: `switch_count` is 0 after reset. It rises by one on each cycle with `array_en` high and stays at its all-ones maximum once it gets there.
- R7: Refills go to slots 0, 1, … in turn and wrap after ENTRIES-1. Once the buffer has wrapped, a refill overwrites the oldest translation, which then misses.
- R8: A refill loads the last-use register with the new translation, so the next lookup to that page needs no array access. A refill that overwrites the page held in the register replaces it.
- R9: `flush` invalidates the last-use register, and so does an array lookup that misses. The next lookup then activates the array.
- R10: Synchronous active-high reset clears all slots, the round-robin pointer, the last-use register, the registered flags and the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vaddr | input | VA_W | Virtual address of the lookup |
| lk_acc | input | 2 | Access code: 0 read, 1 write, 2 execute, 3 never permitted |
| fill_valid | input | 1 | Write a translation into the next round-robin slot |
| fill_vpn | input | VA_W-log2(PAGE_BYTES) | Virtual page number to refill |
| fill_ppn | input | PA_W-log2(PAGE_BYTES) | Physical page number to refill |
| fill_perm | input | 3 | Permission bits {execute, write, read} |
| flush | input | 1 | Invalidate the last-use register |
| pa | output | PA_W | Physical address, combinational (page number is zero when not found) |
| array_en | output | 1 | Entry array activated this cycle |
| hit_q | output | 1 | Previous lookup hit and was permitted |
| miss_q | output | 1 | Previous lookup found no translation |
| fault_q | output | 1 | Previous lookup was found but not permitted |
| switch_count | output | CNT_W | Saturating count of array activations |

## Verification
The address and `array_en` depend only on the current lookup and the held state. The bench drives each lookup on a falling edge and samples them one nanosecond later, in the same cycle. The flags and the counter change at the next rising edge, so they are sampled one nanosecond after that edge. Each check therefore reads the result of exactly one lookup. Refills and flushes are applied in cycles with no lookup. Their effect on the last-use register shows up in the `array_en` value of the next lookup. A reduced counter width makes it possible to reach and check saturation.

// File: rtl/lastuse_tlb_pkg.sv
package lastuse_tlb_pkg;

    typedef struct packed {
        logic x;
        logic w;
        logic r;
    } perm_t;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_NONE  = 2'd3
    } acc_e;

    function automatic logic perm_ok(perm_t p, logic [1:0] acc);
        case (acc)
            ACC_READ:  return p.r;
            ACC_WRITE: return p.w;
            ACC_EXEC:  return p.x;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
    import lastuse_tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_en,
    input  logic [VPN_W-1:0] rd_vpn,
    input  logic             wr_en,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [PPN_W-1:0] wr_ppn,
    input  perm_t            wr_perm,
    output logic             rd_found,
    output logic [PPN_W-1:0] rd_ppn,
    output perm_t            rd_perm
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] valid_q;
    logic [VPN_W-1:0]   vpn_q  [ENTRIES];
    logic [PPN_W-1:0]   ppn_q  [ENTRIES];
    perm_t              perm_q [ENTRIES];
    logic [IDX_W-1:0]   rr_q;
    logic [ENTRIES-1:0] match;

    // word lines: a slot compares only while the array is enabled
    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
            assign match[g] = rd_en && valid_q[g] && (vpn_q[g] == rd_vpn);
        end
    endgenerate

    always_comb begin
        rd_found = 1'b0;
        rd_ppn   = '0;
        rd_perm  = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                rd_found = 1'b1;
                rd_ppn   = ppn_q[i];
                rd_perm  = perm_q[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            rr_q    <= '0;
        end else if (wr_en) begin
            valid_q[rr_q] <= 1'b1;
            rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            vpn_q[rr_q]  <= wr_vpn;
            ppn_q[rr_q]  <= wr_ppn;
            perm_q[rr_q] <= wr_perm;
        end
    end

    assert_fill_slot_R7: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> valid_q[$past(rr_q)]);

    assert_idle_array_R4: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> !rd_found);

endmodule

// File: rtl/tlb_last_use.sv
module tlb_last_use
    import lastuse_tlb_pkg::*;
#(
    parameter int VPN_W = 20,
    parameter int PPN_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  perm_t            fill_perm,
    input  logic             upd_en,
    input  logic             upd_found,
    input  logic [VPN_W-1:0] upd_vpn,
    input  logic [PPN_W-1:0] upd_ppn,
    input  perm_t            upd_perm,
    output logic             lu_valid,
    output logic [VPN_W-1:0] lu_vpn,
    output logic [PPN_W-1:0] lu_ppn,
    output perm_t            lu_perm
);
    always_ff @(posedge clk) begin
        if (rst || flush) begin
            lu_valid <= 1'b0;
            lu_vpn   <= '0;
            lu_ppn   <= '0;
            lu_perm  <= '0;
        end else if (fill_en) begin
            lu_valid <= 1'b1;
            lu_vpn   <= fill_vpn;
            lu_ppn   <= fill_ppn;
            lu_perm  <= fill_perm;
        end else if (upd_en) begin
            lu_valid <= upd_found;
            lu_vpn   <= upd_vpn;
            lu_ppn   <= upd_ppn;
            lu_perm  <= upd_perm;
        end
    end

    assert_flush_clears_R9: assert property (@(posedge clk) disable iff (rst)
        flush |=> !lu_valid);

    assert_fill_loads_R8: assert property (@(posedge clk) disable iff (rst)
        (fill_en && !flush) |=> (lu_valid && lu_vpn == $past(fill_vpn)));

endmodule

// File: rtl/tlb_switch_count.sv
module tlb_switch_count #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (inc && count != CNT_MAX)
            count <= count + 1'b1;
    end

    assert_count_sat_R6: assert property (@(posedge clk) disable iff (rst)
        (count == CNT_MAX) |=> (count == CNT_MAX));

    assert_count_step_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (count == $past(count) || count == $past(count) + 1'b1));

endmodule

// File: rtl/lastuse_tlb.sv
module lastuse_tlb
    import lastuse_tlb_pkg::*;
#(
    parameter int ENTRIES    = 8,
    parameter int VA_W       = 32,
    parameter int PA_W       = 32,
    parameter int PAGE_BYTES = 4096,
    parameter int CNT_W      = 32,
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int VPN_W     = VA_W - OFF_W,
    localparam int PPN_W     = PA_W - OFF_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lk_valid,
    input  logic [VA_W-1:0]  lk_vaddr,
    input  logic [1:0]       lk_acc,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic [2:0]       fill_perm,
    input  logic             flush,
    output logic [PA_W-1:0]  pa,
    output logic             array_en,
    output logic             hit_q,
    output logic             miss_q,
    output logic             fault_q,
    output logic [CNT_W-1:0] switch_count
);
    logic [VPN_W-1:0] vpn;
    logic [OFF_W-1:0] off;
    logic             lu_valid;
    logic [VPN_W-1:0] lu_vpn;
    logic [PPN_W-1:0] lu_ppn;
    perm_t            lu_perm;
    logic             arr_found;
    logic [PPN_W-1:0] arr_ppn;
    perm_t            arr_perm;
    logic             sel_found;
    logic [PPN_W-1:0] sel_ppn;
    perm_t            sel_perm;
    logic             allowed;

    assign vpn = lk_vaddr[VA_W-1:OFF_W];
    assign off = lk_vaddr[OFF_W-1:0];

    // page switch: different page or no held translation
    assign array_en = lk_valid && (!lu_valid || (vpn != lu_vpn));

    tlb_entry_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_store (
        .clk(clk), .rst(rst),
        .rd_en(array_en), .rd_vpn(vpn),
        .wr_en(fill_valid), .wr_vpn(fill_vpn), .wr_ppn(fill_ppn),
        .wr_perm(perm_t'(fill_perm)),
        .rd_found(arr_found), .rd_ppn(arr_ppn), .rd_perm(arr_perm)
    );

    tlb_last_use #(.VPN_W(VPN_W), .PPN_W(PPN_W)) u_last (
        .clk(clk), .rst(rst), .flush(flush),
        .fill_en(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .fill_perm(perm_t'(fill_perm)),
        .upd_en(array_en), .upd_found(arr_found), .upd_vpn(vpn),
        .upd_ppn(arr_ppn), .upd_perm(arr_perm),
        .lu_valid(lu_valid), .lu_vpn(lu_vpn), .lu_ppn(lu_ppn), .lu_perm(lu_perm)
    );

    tlb_switch_count #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .inc(array_en), .count(switch_count)
    );

    always_comb begin
        if (array_en) begin
            sel_found = arr_found;
            sel_ppn   = arr_ppn;
            sel_perm  = arr_perm;
        end else begin
            sel_found = lk_valid && lu_valid;
            sel_ppn   = lu_ppn;
            sel_perm  = lu_perm;
        end
    end

    assign allowed = perm_ok(sel_perm, lk_acc);
    assign pa      = {(sel_found ? sel_ppn : PPN_W'(0)), off};

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_q   <= 1'b0;
            miss_q  <= 1'b0;
            fault_q <= 1'b0;
        end else begin
            hit_q   <= lk_valid && sel_found && allowed;
            miss_q  <= lk_valid && !sel_found;
            fault_q <= lk_valid && sel_found && !allowed;
        end
    end

    assert_one_flag_R5: assert property (@(posedge clk) disable iff (rst)
        $past(lk_valid) |-> $countones({hit_q, miss_q, fault_q}) == 1);

    assert_idle_flags_R5: assert property (@(posedge clk) disable iff (rst)
        !$past(lk_valid) |-> !(hit_q || miss_q || fault_q));

    assert_miss_needs_array_R3: assert property (@(posedge clk) disable iff (rst)
        miss_q |-> $past(array_en));

    assert_reuse_has_entry_R3: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && !array_en) |-> lu_valid);

endmodule

// File: tb/lastuse_tlb_bench.sv
`timescale 1ns/1ps
module lastuse_tlb_bench;
    localparam int CW = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        lk_valid;
    logic [31:0] lk_vaddr;
    logic [1:0]  lk_acc;
    logic        fill_valid;
    logic [19:0] fill_vpn;
    logic [19:0] fill_ppn;
    logic [2:0]  fill_perm;
    logic        flush;
    logic [31:0] pa;
    logic        array_en, hit_q, miss_q, fault_q;
    logic [CW-1:0] switch_count;

    int total = 0;
    int bad   = 0;
    int exp_cnt = 0;

    always #4 clk = ~clk;

    lastuse_tlb #(.ENTRIES(8), .VA_W(32), .PA_W(32), .PAGE_BYTES(4096), .CNT_W(CW)) u_lastuse_tlb (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_acc(lk_acc),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .fill_perm(fill_perm), .flush(flush), .pa(pa), .array_en(array_en),
        .hit_q(hit_q), .miss_q(miss_q), .fault_q(fault_q), .switch_count(switch_count)
    );

    typedef struct packed {
        logic [31:0] va;
        logic [1:0]  acc;
        logic        en;
        logic        hit;
        logic        miss;
        logic        fault;
        logic [31:0] pa;
    } vec_t;

    // after refills of pages 0x10 (r), 0x11 (rw), 0x12 (x); held page is 0x12
    localparam vec_t VECS [10] = '{
        '{32'h0001_0123, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0008_0123},
        '{32'h0001_0FFF, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0008_0FFF},
        '{32'h0001_0004, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0},
        '{32'h0001_1010, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0008_1010},
        '{32'h0001_1020, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0},
        '{32'h0001_2000, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0008_2000},
        '{32'h0001_3000, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0000_0000},
        '{32'h0001_3004, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0000_0004},
        '{32'h0001_2008, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0},
        '{32'h0001_2010, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic look(input logic [31:0] va, input logic [1:0] acc, input logic en,
                        input logic h, input logic m, input logic f,
                        input logic [31:0] epa, input string tag);
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = va; lk_acc = acc;
        #1;
        chk({tag, " array_en"}, 32'(array_en), 32'(en));
        if (h) chk({tag, " pa"}, pa, epa);
        @(posedge clk);
        if (en && exp_cnt < 15) exp_cnt++;
        #1;
        chk({tag, " flags"}, {29'd0, hit_q, miss_q, fault_q}, {29'd0, h, m, f});
        chk({tag, " count"}, 32'(switch_count), 32'(exp_cnt));
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic fill(input logic [19:0] v, input logic [19:0] p, input logic [2:0] pm);
        @(negedge clk);
        fill_valid = 1'b1; fill_vpn = v; fill_ppn = p; fill_perm = pm;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total + 1, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; lk_valid = 0; lk_vaddr = 0; lk_acc = 0;
        fill_valid = 0; fill_vpn = 0; fill_ppn = 0; fill_perm = 0; flush = 0;
        repeat (4) @(posedge clk);
        #1;
        // R10 reset state
        chk("R10 flags", {29'd0, hit_q, miss_q, fault_q}, 32'd0);
        chk("R10 count", 32'(switch_count), 32'd0);
        chk("R10 array_en", 32'(array_en), 32'd0);
        @(negedge clk); rst = 1'b0;
        // R10: no slot valid after reset
        look(32'h0001_0000, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0, "R10 empty");

        fill(20'h00010, 20'h00080, 3'b001);
        fill(20'h00011, 20'h00081, 3'b011);
        fill(20'h00012, 20'h00082, 3'b100);

        // table: R1 R2 R3 R4 R5 R9
        for (int i = 0; i < 10; i++)
            look(VECS[i].va, VECS[i].acc, VECS[i].en, VECS[i].hit, VECS[i].miss,
                 VECS[i].fault, VECS[i].pa, $sformatf("R1/R2/R3/R4 vec%0d", i));

        // R5: idle cycle clears flags
        @(posedge clk); #1;
        chk("R5 idle flags", {29'd0, hit_q, miss_q, fault_q}, 32'd0);

        // R8: refill loads the held translation
        fill(20'h00013, 20'h00093, 3'b011);
        look(32'h0001_3ABC, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0009_3ABC, "R8 reuse after fill");

        // R9: flush forces array access
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        look(32'h0001_3000, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0009_3000, "R9 after flush");

        // R7: wrap, slot 0 (page 0x10) overwritten by page 0x24
        fill(20'h00020, 20'h000A0, 3'b001);
        fill(20'h00021, 20'h000A1, 3'b001);
        fill(20'h00022, 20'h000A2, 3'b001);
        fill(20'h00023, 20'h000A3, 3'b001);
        fill(20'h00024, 20'h000A4, 3'b001);
        look(32'h0001_0000, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0, "R7 oldest evicted");
        look(32'h0002_4010, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h000A_4010, "R7 wrapped slot");
        look(32'h0001_1000, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0008_1000, "R7 slot1 kept");
        look(32'h0002_0000, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h000A_0000, "R7 slot4");
        look(32'h0001_1000, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0008_1000, "R7 slot1 again");

        // R8: refill overwrites held page 0x11 in slot 1
        fill(20'h00030, 20'h000B0, 3'b111);
        look(32'h0001_1000, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0, "R8 overwritten held page");
        look(32'h0003_0000, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 32'h000B_0000, "R8 new page");

        // R6 saturation: alternate pages so each lookup switches
        for (int k = 0; k < 4; k++) begin
            look(32'h0002_4000, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h000A_4000, "R6 switch a");
            look(32'h0003_0000, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 32'h000B_0000, "R6 switch b");
        end
        chk("R6 saturated", 32'(switch_count), 32'd15);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule